// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block controls the analog-input path of a multichannel data-acquisition front end. The host describes each channel to sample as a four-word descriptor. It feeds each 16-bit word through an 8-bit-significant scan-list port as two byte writes. The words gather in a scan-list FIFO. A start command lets a loader collect four words at a time into a single-entry configuration pipe.

Once the pacer is enabled, each pacer period takes the channel waiting in the pipe and issues one conversion request to the converter. The converter is modelled as a request/acknowledge data source. The returned sample is written into a results FIFO, which the host reads through its own port.

One shared offset (0x00) holds a write-only command register and a read-only status register. The command register takes FIFO and pipe reset codes, start/stop codes for the scan list and enable/disable codes for the pacer. Any other value written there is ignored.

A descriptor can carry an end-of-scan mark. After that channel's result is stored, acquisition stops until the pacer is enabled again.

Top module: `acq_seq_top`

## Requirements
- R1: Writing to offset 0x00 issues a command. Value 0x0011 lets the loader move scan-list words into the configuration pipe, 0x0010 halts the loader, 0x0031 enables the pacer, restarts its count and arms scanning, and 0x0030 disables the pacer and disarms scanning. Any value that is neither one of these four nor a reset code leaves the block unchanged.
- R2: A command value in the range 0x0001..0x0007 is a reset code, and its bits combine. Bit 2 empties the scan-list FIFO and drops a half-written word. Bit 1 empties the results FIFO and clears its overrun flag. Bit 0 empties the configuration pipe, aborts any outstanding conversion (the request drops at the next edge), disarms scanning and clears the pacer-overrun flag.
- R3: Each write to the scan-list port (offset 0x02) delivers one byte in data bits 7:0, and higher data bits are ignored. The first write of a pair is the low byte of a word and the second is the high byte. The completed word enters the scan-list FIFO.
- R4: The loader takes words from the scan-list FIFO, in order, only while started. It holds them until four have arrived (words 0..3 of one descriptor), then marks the configuration pipe full. It loads nothing more until that descriptor is consumed by a conversion.
- R5: Reading offset 0x00 returns status: bit0 results FIFO holds two or more samples, bit1 results FIFO not empty, bit2 results overrun, bit3 scanning armed, bit4 configuration pipe full, bit5 scan-list FIFO empty, bit6 conversion outstanding, bit8 pacer overrun. All other bits read 0, so the value after reset is 0x0020.
- R6: The pacer period is the 48-bit value {high register (offset 0x0C, bits 15:0), low register (offset 0x08, bits 31:0)}, with 0 behaving as 1. While scanning is armed and the pipe is full, one conversion starts every period, so successive request rises are exactly one period apart.
- R7: The converter channel is 4*bank + word2 bits 7:6. The bank comes from word3 bits 6:0: 0x01 is bank 0, 0x02 bank 1, 0x05 bank 2, 0x06 bank 3, 0x41 bank 4, 0x42 bank 5, and any other code selects channel 0. Channels 0..7 are reported differential (adc_diff=1) and 8..23 single ended.
- R8: When the conversion of a descriptor whose word1 bit 2 is set completes, its sample is stored and scanning is disarmed. Later pacer periods start no conversion until the pacer is enabled again.
- R9: A sample that completes while the results FIFO is full is dropped. The results overrun flag then stays set until a results reset, and the stored samples are unaffected.
- R10: A pacer period that ends while a conversion is outstanding starts no second request. Instead it sets the pacer-overrun flag, which stays set until a pipe reset.
- R11: Reading offset 0x04 returns the oldest stored sample and, when the read strobe is given, removes it. With the FIFO empty the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Register byte offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe; pops the results FIFO at offset 0x04 |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| adc_req | output | 1 | Conversion request, held until acknowledged |
| adc_chan | output | 5 | Channel to convert |
| adc_diff | output | 1 | 1 when the channel is differential |
| adc_ack | input | 1 | One-cycle acknowledge carrying a sample |
| adc_data | input | 16 | Sample value, valid with adc_ack |

## Verification
On every cycle, the assertions check several properties. The request is held steady until acknowledged, and a pacer period during an outstanding conversion raises the overrun flag. Both overrun flags are sticky. A full FIFO is never pushed, and an empty one is never popped. The loaded descriptor cannot change while it waits, and a pipe reset aborts the scan in one edge. Some behaviours show only in the bench's scenarios: the exact pacer spacing, the channel and bank mapping, byte ordering and the recovery from a half-written word, the status encodings after each step, and which samples survive a results overflow.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  localparam int REG_W   = 16;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int CHAN_W  = 5;
  localparam int DIV_LO_W = 32;
  localparam int DIV_HI_W = 16;
  localparam int DIV_W   = DIV_LO_W + DIV_HI_W;
  localparam int WORDS_PER_DESC = 4;

  localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SCAN   = 8'h02;
  localparam logic [ADDR_W-1:0] OFS_RESULT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIV_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIV_HI = 8'h0C;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_LOAD_GO,
    CMD_LOAD_HALT,
    CMD_PACE_ON,
    CMD_PACE_OFF
  } cmd_e;

  typedef logic [WORDS_PER_DESC-1:0][REG_W-1:0] desc_t;

  function automatic cmd_e cmd_decode(input logic [REG_W-1:0] v);
    cmd_e c;
    case (v)
      16'h0011: c = CMD_LOAD_GO;
      16'h0010: c = CMD_LOAD_HALT;
      16'h0031: c = CMD_PACE_ON;
      16'h0030: c = CMD_PACE_OFF;
      default:  c = (v[REG_W-1:3] == '0 && v[2:0] != 3'b000) ? CMD_RESET : CMD_NONE;
    endcase
    return c;
  endfunction

  // bank select code in word3 -> channel number
  function automatic logic [CHAN_W-1:0] chan_of(input logic [1:0] low_bits,
                                                input logic [6:0] bank_code);
    logic [2:0] bank;
    logic       ok;
    ok = 1'b1;
    case (bank_code)
      7'h01:   bank = 3'd0;
      7'h02:   bank = 3'd1;
      7'h05:   bank = 3'd2;
      7'h06:   bank = 3'd3;
      7'h41:   bank = 3'd4;
      7'h42:   bank = 3'd5;
      default: begin bank = 3'd0; ok = 1'b0; end
    endcase
    return ok ? {bank, low_bits} : '0;
  endfunction

  function automatic logic is_diff(input logic [CHAN_W-1:0] ch);
    return ch < CHAN_W'(8);
  endfunction

  function automatic logic [DIV_W-1:0] pace_limit(input logic [DIV_LO_W-1:0] lo,
                                                  input logic [DIV_HI_W-1:0] hi);
    logic [DIV_W-1:0] p;
    p = {hi, lo};
    return (p == '0) ? '0 : p - DIV_W'(1);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic res_multi, input logic res_any, input logic res_ovr,
    input logic scanning,  input logic pipe_full, input logic scan_empty,
    input logic conv_busy, input logic pace_ovr);
    logic [REG_W-1:0] s;
    s = '0;
    s[0] = res_multi;
    s[1] = res_any;
    s[2] = res_ovr;
    s[3] = scanning;
    s[4] = pipe_full;
    s[5] = scan_empty;
    s[6] = conv_busy;
    s[8] = pace_ovr;
    return s;
  endfunction

endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [$clog2(DEPTH):0] count,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full    = count == (AW+1)'(DEPTH);
  assign empty   = count == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // the owner must gate pushes when full (R9 drops samples on a full FIFO)
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |-> !push);
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

endmodule

// File: rtl/acq_byte_join.sv
module acq_byte_join #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                byte_wr,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic                word_push,
  output logic [2*BYTE_W-1:0] word_out
);
  logic              hi_phase_q;
  logic [BYTE_W-1:0] low_q;

  assign word_push = byte_wr && hi_phase_q && !clr;
  assign word_out  = {byte_in, low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_phase_q <= 1'b0;
      low_q      <= '0;
    end else if (clr) begin
      hi_phase_q <= 1'b0;
    end else if (byte_wr) begin
      hi_phase_q <= !hi_phase_q;
      if (!hi_phase_q) low_q <= byte_in;
    end
  end

  p_pair_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |=> !hi_phase_q);
  p_pair_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !hi_phase_q && !clr) |=> (hi_phase_q && !word_push));

endmodule

// File: rtl/acq_pacer.sv
module acq_pacer
  import acq_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                restart,
  input  logic [DIV_LO_W-1:0] div_lo,
  input  logic [DIV_HI_W-1:0] div_hi,
  output logic                tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit = pace_limit(div_lo, div_hi);
  assign tick  = enable && !restart && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || !enable) cnt_q <= '0;
    else if (tick)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end

  p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0));

endmodule

// File: rtl/acq_cfg_pipe.sv
module acq_cfg_pipe
  import acq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             src_empty,
  input  logic [REG_W-1:0] src_word,
  input  logic             consume,
  output logic             src_pop,
  output logic             full,
  output desc_t            desc
);
  localparam int CW = $clog2(WORDS_PER_DESC);

  logic [CW-1:0] wcnt_q;
  desc_t         stage_q;

  assign src_pop = run && !src_empty && !full && !clr;
  assign desc    = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      full    <= 1'b0;
      stage_q <= '0;
    end else if (clr) begin
      wcnt_q <= '0;
      full   <= 1'b0;
    end else begin
      if (consume) full <= 1'b0;
      if (src_pop) begin
        stage_q[wcnt_q] <= src_word;
        if (wcnt_q == CW'(WORDS_PER_DESC - 1)) begin
          wcnt_q <= '0;
          full   <= 1'b1;
        end else begin
          wcnt_q <= wcnt_q + CW'(1);
        end
      end
    end
  end

  p_desc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !consume && !clr) |=> (full && $stable(desc)));
  p_consume_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> full);

endmodule

// File: rtl/acq_seq_top.sv
module acq_seq_top
  import acq_seq_pkg::*;
#(
  parameter int SCAN_DEPTH = 16,
  parameter int RES_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic              adc_req,
  output logic [CHAN_W-1:0] adc_chan,
  output logic              adc_diff,
  input  logic              adc_ack,
  input  logic [REG_W-1:0]  adc_data
);
  localparam int SCAN_CW = $clog2(SCAN_DEPTH) + 1;
  localparam int RES_CW  = $clog2(RES_DEPTH) + 1;

  // ---------------- command decode ----------------
  cmd_e cmd;
  logic cmd_wr, clr_scan, clr_res, clr_pipe;
  logic go_load, halt_load, pace_on, pace_off;

  assign cmd       = cmd_decode(host_wdata[REG_W-1:0]);
  assign cmd_wr    = host_wr && host_addr == OFS_CMD;
  assign clr_pipe  = cmd_wr && cmd == CMD_RESET && host_wdata[0];
  assign clr_res   = cmd_wr && cmd == CMD_RESET && host_wdata[1];
  assign clr_scan  = cmd_wr && cmd == CMD_RESET && host_wdata[2];
  assign go_load   = cmd_wr && cmd == CMD_LOAD_GO;
  assign halt_load = cmd_wr && cmd == CMD_LOAD_HALT;
  assign pace_on   = cmd_wr && cmd == CMD_PACE_ON;
  assign pace_off  = cmd_wr && cmd == CMD_PACE_OFF;

  // ---------------- scan-list path ----------------
  logic             word_push;
  logic [REG_W-1:0] word_val;
  logic             scan_pop, scan_full, scan_empty;
  logic [REG_W-1:0] scan_word;
  logic [SCAN_CW-1:0] scan_cnt;

  acq_byte_join #(.BYTE_W(REG_W/2)) u_join (
    .clk(clk), .rst_n(rst_n), .clr(clr_scan),
    .byte_wr(host_wr && host_addr == OFS_SCAN),
    .byte_in(host_wdata[REG_W/2-1:0]),
    .word_push(word_push), .word_out(word_val));

  acq_fifo #(.W(REG_W), .DEPTH(SCAN_DEPTH)) u_scan_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr_scan),
    .push(word_push && !scan_full), .din(word_val),
    .pop(scan_pop), .dout(scan_word), .count(scan_cnt),
    .full(scan_full), .empty(scan_empty));

  // ---------------- configuration pipe ----------------
  logic  load_run_q;
  logic  pipe_full, conv_start;
  desc_t pipe_desc;

  acq_cfg_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .clr(clr_pipe), .run(load_run_q),
    .src_empty(scan_empty), .src_word(scan_word), .consume(conv_start),
    .src_pop(scan_pop), .full(pipe_full), .desc(pipe_desc));

  // ---------------- pacer ----------------
  logic                pace_en_q, tick;
  logic [DIV_LO_W-1:0] div_lo_q;
  logic [DIV_HI_W-1:0] div_hi_q;

  acq_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .enable(pace_en_q), .restart(pace_on),
    .div_lo(div_lo_q), .div_hi(div_hi_q), .tick(tick));

  // ---------------- conversion engine ----------------
  logic scan_armed_q, busy_q, cur_last_q;
  logic res_ovr_q, pace_ovr_q;
  logic conv_done, res_push, res_drop, res_pop;
  logic [CHAN_W-1:0]  cur_chan_q;
  logic [REG_W-1:0]   res_word;
  logic [RES_CW-1:0]  res_cnt;
  logic               res_full, res_empty;

  assign conv_start = tick && scan_armed_q && pipe_full && !busy_q && !clr_pipe;
  assign conv_done  = busy_q && adc_ack && !clr_pipe;
  assign res_push   = conv_done && !res_full;
  assign res_drop   = conv_done && res_full;
  assign res_pop    = host_rd && host_addr == OFS_RESULT && !res_empty;

  acq_fifo #(.W(REG_W), .DEPTH(RES_DEPTH)) u_res_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr_res),
    .push(res_push), .din(adc_data),
    .pop(res_pop), .dout(res_word), .count(res_cnt),
    .full(res_full), .empty(res_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_run_q   <= 1'b0;
      pace_en_q    <= 1'b0;
      scan_armed_q <= 1'b0;
      busy_q       <= 1'b0;
      cur_chan_q   <= '0;
      cur_last_q   <= 1'b0;
      res_ovr_q    <= 1'b0;
      pace_ovr_q   <= 1'b0;
      div_lo_q     <= '0;
      div_hi_q     <= '0;
    end else begin
      if (go_load)        load_run_q <= 1'b1;
      else if (halt_load) load_run_q <= 1'b0;

      if (pace_on)       pace_en_q <= 1'b1;
      else if (pace_off) pace_en_q <= 1'b0;

      if (clr_pipe)                     scan_armed_q <= 1'b0;
      else if (pace_on)                 scan_armed_q <= 1'b1;
      else if (pace_off)                scan_armed_q <= 1'b0;
      else if (conv_done && cur_last_q) scan_armed_q <= 1'b0;

      if (clr_pipe)        busy_q <= 1'b0;
      else if (conv_start) busy_q <= 1'b1;
      else if (conv_done)  busy_q <= 1'b0;

      if (conv_start) begin
        cur_chan_q <= chan_of(pipe_desc[2][7:6], pipe_desc[3][6:0]);
        cur_last_q <= pipe_desc[1][2];
      end

      if (clr_res)       res_ovr_q <= 1'b0;
      else if (res_drop) res_ovr_q <= 1'b1;

      if (clr_pipe)            pace_ovr_q <= 1'b0;
      else if (tick && busy_q) pace_ovr_q <= 1'b1;

      if (host_wr && host_addr == OFS_DIV_LO) div_lo_q <= host_wdata;
      if (host_wr && host_addr == OFS_DIV_HI) div_hi_q <= host_wdata[DIV_HI_W-1:0];
    end
  end

  assign adc_req  = busy_q;
  assign adc_chan = cur_chan_q;
  assign adc_diff = is_diff(cur_chan_q);

  // ---------------- host read ----------------
  logic [REG_W-1:0] status;
  assign status = pack_status(res_cnt > RES_CW'(1), !res_empty, res_ovr_q,
                              scan_armed_q, pipe_full, scan_empty, busy_q, pace_ovr_q);

  always_comb begin
    case (host_addr)
      OFS_CMD:    host_rdata = status;
      OFS_RESULT: host_rdata = res_empty ? '0 : res_word;
      default:    host_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  p_ignore_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == CMD_NONE) |=> ($stable(load_run_q) && $stable(pace_en_q)));
  p_pipe_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pipe |=> (!adc_req && !scan_armed_q && !pipe_full && !pace_ovr_q));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack && !clr_pipe) |=> (adc_req && $stable(adc_chan)));
  p_last_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && cur_last_q && !pace_on) |=> !scan_armed_q);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ovr_q && !clr_res) |=> res_ovr_q);
  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && adc_ack && res_full && !clr_res && !clr_pipe) |=> res_ovr_q);
  p_tick_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && adc_req && !clr_pipe) |=> pace_ovr_q);
  p_pace_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_ovr_q && !clr_pipe) |=> pace_ovr_q);

endmodule

// File: tb/acq_seq_top_tb_top.sv
`timescale 1ns/1ps
module acq_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        adc_req, adc_diff;
  logic [4:0]  adc_chan;
  logic        adc_ack = 1'b0;
  logic [15:0] adc_data = '0;

  always #2.5 clk = ~clk;

  acq_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_diff(adc_diff),
    .adc_ack(adc_ack), .adc_data(adc_data));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // converter model and monitors
  int   cyc = 0;
  bit   ack_en = 1;
  int   adc_lat = 2;
  int   n_conv = 0;
  int   n_rise = 0;
  int   rise_cyc [64];
  logic [4:0]  obs_chan [64];
  logic        obs_diff [64];
  logic [15:0] obs_data [64];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int wcnt;
    bit req_prev;
    wcnt = 0;
    req_prev = 0;
    forever begin
      @(negedge clk);
      if (adc_req && !req_prev) begin
        rise_cyc[n_rise % 64] = cyc;
        n_rise++;
      end
      req_prev = adc_req;
      if (adc_ack) begin
        adc_ack = 1'b0;
      end else if (adc_req && ack_en) begin
        if (wcnt >= adc_lat) begin
          adc_data = 16'h8000 | (16'(adc_chan) << 8) | 16'(n_conv[7:0]);
          obs_chan[n_conv % 64] = adc_chan;
          obs_diff[n_conv % 64] = adc_diff;
          obs_data[n_conv % 64] = adc_data;
          n_conv++;
          adc_ack = 1'b1;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end else if (!adc_req) begin
        wcnt = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  localparam logic [7:0] A_CMD = 8'h00, A_SCAN = 8'h02, A_RES = 8'h04,
                         A_LO = 8'h08, A_HI = 8'h0C;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #0.5 d = host_rdata;
  endtask

  task automatic pop_result(output logic [15:0] d);
    @(negedge clk);
    host_addr = A_RES; host_rd = 1'b1;
    #0.5 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_status(int b, logic v, string req);
    logic [15:0] s;
    int k;
    for (k = 0; k < 3000; k++) begin
      peek(A_CMD, s);
      if (s[b] === v) break;
    end
    if (k == 3000) chk(req, "status bit wait timed out", 32'(s[b]), 32'(v));
  endtask

  task automatic wait_conv(int target, string req);
    int k;
    for (k = 0; k < 3000; k++) begin
      if (n_conv >= target) break;
      @(negedge clk);
    end
    if (k == 3000) chk(req, "conversion count wait timed out", 32'(n_conv), 32'(target));
    idle(3);
  endtask

  // a word goes out low byte then high byte, with junk above bit 7
  task automatic load_word(logic [15:0] w);
    bus_write(A_SCAN, {24'hA5C35A, w[7:0]});
    bus_write(A_SCAN, {24'h3C5AA5, w[15:8]});
  endtask

  function automatic logic [6:0] bank_code(int ch);
    int b;
    b = ch / 4;
    if (b == 0) return 7'h01;
    if (b == 1) return 7'h02;
    if (b == 2) return 7'h05;
    if (b == 3) return 7'h06;
    if (b == 4) return 7'h41;
    return 7'h42;
  endfunction

  task automatic load_desc(int ch, bit last);
    load_word(16'h0000);
    load_word(last ? 16'h0004 : 16'h0000);
    load_word(16'h0800 | 16'((ch % 4) << 6));
    load_word(16'hC000 | 16'(bank_code(ch)));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state;
    logic [15:0] s;
    peek(A_CMD, s);
    chk("R5", "status after reset", 32'(s), 32'h0020);
    chk("R5", "no request after reset", 32'(adc_req), 0);
    peek(A_RES, s);
    chk("R11", "empty results read", 32'(s), 0);
  endtask

  task automatic t_single;
    logic [15:0] s, d;
    int base;
    bus_write(A_CMD, 32'h0007);
    bus_write(A_LO, 32'd10);
    bus_write(A_HI, 32'd0);
    load_desc(13, 1);
    peek(A_CMD, s);
    chk("R3", "scan list holds words, not started", 32'(s), 32'h0000);
    base = n_conv;
    adc_lat = 6;
    bus_write(A_CMD, 32'h0011);
    wait_status(4, 1'b1, "R4");
    peek(A_CMD, s);
    chk("R4", "pipe full, scan list drained", 32'(s), 32'h0030);
    bus_write(A_CMD, 32'h0031);
    peek(A_CMD, s);
    chk("R1", "scanning armed by pacer enable", 32'(s), 32'h0038);
    wait_status(6, 1'b1, "R6");
    peek(A_CMD, s);
    chk("R5", "status during conversion", 32'(s), 32'h0068);
    chk("R7", "channel 13 selected", 32'(adc_chan), 32'd13);
    chk("R7", "channel 13 single ended", 32'(adc_diff), 0);
    wait_status(1, 1'b1, "R8");
    peek(A_CMD, s);
    chk("R8", "last entry ends scanning", 32'(s), 32'h0022);
    pop_result(d);
    chk("R11", "single sample value", 32'(d), 32'(obs_data[base % 64]));
    idle(30);
    chk("R8", "no further conversion after last", 32'(n_conv), 32'(base + 1));
    peek(A_CMD, s);
    chk("R11", "results empty after pop", 32'(s), 32'h0020);
    bus_write(A_CMD, 32'h0030);
    bus_write(A_CMD, 32'h0010);
  endtask

  task automatic t_multi;
    logic [15:0] s, d;
    int base, rbase;
    bus_write(A_CMD, 32'h0007);
    bus_write(A_LO, 32'd20);
    adc_lat = 2;
    load_desc(2, 0);
    load_desc(7, 0);
    load_desc(22, 1);
    bus_write(A_CMD, 32'h0011);
    wait_status(4, 1'b1, "R4");
    base = n_conv;
    rbase = n_rise;
    bus_write(A_CMD, 32'h0031);
    wait_conv(base + 3, "R6");
    chk("R6", "period between first and second request", 32'(rise_cyc[(rbase+1)%64] - rise_cyc[rbase%64]), 32'd20);
    chk("R6", "period between second and third request", 32'(rise_cyc[(rbase+2)%64] - rise_cyc[(rbase+1)%64]), 32'd20);
    chk("R7", "first channel", 32'(obs_chan[base%64]), 32'd2);
    chk("R7", "first channel differential", 32'(obs_diff[base%64]), 1);
    chk("R7", "second channel", 32'(obs_chan[(base+1)%64]), 32'd7);
    chk("R7", "second channel differential", 32'(obs_diff[(base+1)%64]), 1);
    chk("R7", "third channel", 32'(obs_chan[(base+2)%64]), 32'd22);
    chk("R7", "third channel single ended", 32'(obs_diff[(base+2)%64]), 0);
    peek(A_CMD, s);
    chk("R5", "three samples held", 32'(s), 32'h0023);
    for (int i = 0; i < 3; i++) begin
      pop_result(d);
      chk("R11", "in-order sample", 32'(d), 32'(obs_data[(base+i)%64]));
    end
    pop_result(d);
    chk("R11", "read of empty results", 32'(d), 0);
    idle(50);
    chk("R8", "pacer alone starts nothing after last", 32'(n_rise), 32'(rbase + 3));
    bus_write(A_CMD, 32'h0030);
  endtask

  task automatic t_pacer_overrun;
    logic [15:0] s, d;
    int base, rbase;
    bus_write(A_CMD, 32'h0007);
    bus_write(A_LO, 32'd4);
    load_desc(9, 1);
    bus_write(A_CMD, 32'h0011);
    wait_status(4, 1'b1, "R4");
    ack_en = 0;
    base = n_conv;
    rbase = n_rise;
    bus_write(A_CMD, 32'h0031);
    idle(30);
    chk("R10", "one request while outstanding", 32'(n_rise), 32'(rbase + 1));
    peek(A_CMD, s);
    chk("R10", "pacer overrun flagged", 32'(s), 32'h0168);
    ack_en = 1;
    wait_status(1, 1'b1, "R10");
    pop_result(d);
    chk("R10", "sample after late acknowledge", 32'(d), 32'(obs_data[base%64]));
    peek(A_CMD, s);
    chk("R10", "pacer overrun sticky", 32'(s), 32'h0120);
    bus_write(A_CMD, 32'h0001);
    peek(A_CMD, s);
    chk("R2", "pipe reset clears pacer overrun", 32'(s), 32'h0020);
    bus_write(A_CMD, 32'h0030);
  endtask

  task automatic t_results_overflow;
    logic [15:0] s, d;
    int base;
    bus_write(A_CMD, 32'h0007);
    bus_write(A_LO, 32'd8);
    adc_lat = 1;
    bus_write(A_CMD, 32'h0011);
    base = n_conv;
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 3; k++) load_desc(r * 3 + k + 8, k == 2);
      wait_status(4, 1'b1, "R9");
      bus_write(A_CMD, 32'h0031);
      wait_conv(base + 3 * (r + 1), "R9");
    end
    peek(A_CMD, s);
    chk("R9", "full results with overrun", 32'(s), 32'h0027);
    for (int i = 0; i < 8; i++) begin
      pop_result(d);
      chk("R9", "kept sample", 32'(d), 32'(obs_data[(base+i)%64]));
    end
    peek(A_CMD, s);
    chk("R9", "overrun sticky after draining", 32'(s), 32'h0024);
    bus_write(A_CMD, 32'h0002);
    peek(A_CMD, s);
    chk("R2", "results reset clears overrun", 32'(s), 32'h0020);
    bus_write(A_CMD, 32'h0030);
  endtask

  task automatic t_ignored;
    logic [15:0] s;
    int rbase;
    bus_write(A_CMD, 32'h0010);
    bus_write(A_CMD, 32'h0007);
    load_desc(5, 1);
    rbase = n_rise;
    bus_write(A_CMD, 32'h0012);
    bus_write(A_CMD, 32'h0008);
    bus_write(A_CMD, 32'h0033);
    bus_write(A_CMD, 32'h1011);
    idle(10);
    peek(A_CMD, s);
    chk("R1", "unknown commands change nothing", 32'(s), 32'h0000);
    chk("R1", "no request from unknown commands", 32'(n_rise), 32'(rbase));
    bus_write(A_CMD, 32'h0011);
    wait_status(4, 1'b1, "R1");
    peek(A_CMD, s);
    chk("R1", "start code loads pipe", 32'(s), 32'h0030);
  endtask

  task automatic t_reset_override;
    logic [15:0] s, d;
    int base;
    bus_write(A_LO, 32'd4);
    ack_en = 0;
    bus_write(A_CMD, 32'h0031);
    wait_status(6, 1'b1, "R2");
    bus_write(A_CMD, 32'h0001);
    peek(A_CMD, s);
    chk("R2", "request dropped by pipe reset", 32'(adc_req), 0);
    chk("R2", "status after pipe reset", 32'(s), 32'h0020);
    bus_write(A_CMD, 32'h0030);
    // orphan byte then scan-list reset
    bus_write(A_SCAN, 32'h000000FF);
    bus_write(A_CMD, 32'h0004);
    peek(A_CMD, s);
    chk("R2", "scan-list reset empties list", 32'(s), 32'h0020);
    load_desc(18, 1);
    wait_status(4, 1'b1, "R3");
    ack_en = 1;
    base = n_conv;
    bus_write(A_CMD, 32'h0031);
    wait_status(1, 1'b1, "R3");
    chk("R3", "word pairing restarts after reset", 32'(obs_chan[base%64]), 32'd18);
    chk("R7", "channel 18 single ended", 32'(obs_diff[base%64]), 0);
    pop_result(d);
    chk("R11", "sample after reset recovery", 32'(d), 32'(obs_data[base%64]));
    bus_write(A_CMD, 32'h0030);
    bus_write(A_CMD, 32'h0010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset_state();
    t_single();
    t_multi();
    t_pacer_overrun();
    t_results_overflow();
    t_ignored();
    t_reset_override();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule